// File: doc/BRIEF.md
# Digital Frequency-Locked Loop Tuner

This block steers a controlled oscillator towards a chosen frequency. It runs on the oscillator's own output clock. A 16-bit counter in that domain counts fast-clock cycles. On every rising edge of a slow reference pulse, the block takes the counter value and subtracts the value it took on the previous reference edge. It compares that count of fast cycles per reference period with a programmable target. It then moves an 8-bit fine tap word one step. When the fine word wraps, it also moves a 3-bit coarse range field one step. With a 4096 Hz reference, the oscillator ends up at the target count times 4096 Hz.

Each run is started by a `start` pulse. The loop stops for good when one measurement equals the target exactly. The tap and range outputs then stay fixed until the next `start`. A target under 64 is refused. In that case no run begins and `reject` pulses high.

The controller is a three-state machine:

- IDLE: the state after reset.
- TRACK: a run is in progress and adjustments are made.
- LOCKED: the run has ended and the outputs are held.

It has four transitions:

- Launch-from-idle: IDLE to TRACK, on `start` with a valid target.
- Relaunch: LOCKED to TRACK, on `start` with a valid target.
- Match: TRACK to LOCKED, when a measurement equals the target.
- Refuse: IDLE stays IDLE, and LOCKED stays LOCKED, on `start` with a target under 64.

Top module: `fll_tuner`

## Requirements
- R1: After reset, `fine_tap` is 0x80, `coarse_sel` is 0, and `busy`, `locked` and `reject` are all low.
- R2: `start` with `target` >= 64 from IDLE or LOCKED enters TRACK on the next clock. From that clock, `busy` is 1 and `locked` is 0, and `fine_tap` and `coarse_sel` keep their values as the starting point.
- R3: `start` with `target` < 64 outside TRACK starts nothing. The state is unchanged, so `busy` stays 0 and `locked` keeps its value. `reject` is 1 for exactly the one clock after that edge.
- R4: A launch clears the cycle counter and zeroes the stored previous capture. The first measurement is therefore the counter value since the clear: it equals N+2 when `ref_in` rises N clocks after the launch edge.
- R5: Each rising edge of `ref_in` while in TRACK is synchronized through two flops. It causes exactly one adjustment. The measurement is the 16-bit modular difference between this capture and the previous one.
- R6: If the measurement is greater than `target`, `fine_tap` decrements. When it wraps from 0x00 to 0xFF, `coarse_sel` decrements.
- R7: If the measurement is less than `target`, `fine_tap` increments. When it wraps from 0xFF to 0x00, `coarse_sel` increments.
- R8: `coarse_sel` saturates at 0 and at 7. `fine_tap` still wraps in that case.
- R9: A measurement equal to `target` enters LOCKED, with `busy` 0 and `locked` 1. Counting stops, and further reference edges leave `fine_tap` and `coarse_sel` unchanged until the next launch.
- R10: `target` is read at each reference edge. A new value given during TRACK takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, taken from the oscillator being tuned |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Slow reference pulse, asynchronous to clk |
| start | input | 1 | Begins a tuning run when not in TRACK |
| target | input | 16 | Wanted number of clk cycles per reference period |
| fine_tap | output | 8 | Fine oscillator tap word |
| coarse_sel | output | 3 | Coarse oscillator range select |
| busy | output | 1 | High while in TRACK |
| locked | output | 1 | High while in LOCKED |
| reject | output | 1 | One-clock pulse when a start with a target under 64 is refused |

## Verification
Three reference patterns exercise the main function:

- A reference period much shorter than the target drives a long climb. This climb separates a single step per edge from wrap carries, and a range carry from range saturation at 7.
- A period longer than the target drives a descent. This descent separates the down-wrap carry from saturation at 0.
- A period equal to the target, reached after one deliberately long first interval, shows that the loop stops on exact equality and holds afterwards.

A first interval that exactly equals the target tells a measurement taken from the counter clear apart from one taken from a stale capture. Targets of 63 and 64 bound the refusal rule. Lowering the target in the middle of a run shows that the comparison uses the present value.

// File: rtl/fll_pkg.sv
package fll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TRACK  = 2'd1,
        ST_LOCKED = 2'd2
    } fll_state_e;

endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_async,
    output logic rise
);
    // sh[0..STAGES-1] synchronize, sh[STAGES] holds the previous synchronized level
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], ref_async};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    // R5: a detected edge lasts one clock only
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/fll_period_meter.sv
module fll_period_meter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          cap,
    output logic [CW-1:0] diff
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            prev_q <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
            prev_q <= '0;
        end else begin
            if (run) cnt_q  <= cnt_q + 1'b1;
            if (cap) prev_q <= cnt_q;
        end
    end

    // modular difference handles counter wrap-around
    assign diff = cnt_q - prev_q;

    // R9: counter frozen outside a run
    assert_count_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q));
    // R4: a clear restarts both counter and stored capture
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && prev_q == '0));
endmodule

// File: rtl/fll_tap_stepper.sv
module fll_tap_stepper #(
    parameter int TW       = 8,
    parameter int RW       = 3,
    parameter int TAP_INIT = 128,
    parameter int RNG_INIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up,
    input  logic          dn,
    output logic [TW-1:0] tap,
    output logic [RW-1:0] rng
);
    localparam logic [TW-1:0] TAP_TOP = '1;
    localparam logic [RW-1:0] RNG_TOP = '1;

    logic [TW-1:0] tap_q;
    logic [RW-1:0] rng_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= TW'(TAP_INIT);
            rng_q <= RW'(RNG_INIT);
        end else if (up) begin
            tap_q <= tap_q + 1'b1;
            if (tap_q == TAP_TOP && rng_q != RNG_TOP) rng_q <= rng_q + 1'b1;
        end else if (dn) begin
            tap_q <= tap_q - 1'b1;
            if (tap_q == '0 && rng_q != '0) rng_q <= rng_q - 1'b1;
        end
    end

    assign tap = tap_q;
    assign rng = rng_q;

    // R7: range moves upward only on a fine wrap
    assert_up_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up && tap_q != TAP_TOP) |=> $stable(rng_q));
    // R6: range moves downward only on a fine wrap
    assert_dn_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && tap_q != '0) |=> $stable(rng_q));
    // R8: saturation at the top
    assert_rng_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (up && rng_q == RNG_TOP) |=> rng_q == RNG_TOP);
    // R8: saturation at the bottom
    assert_rng_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && rng_q == '0) |=> rng_q == '0);
    // R5: never two directions in one clock
    assert_one_direction_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));
endmodule

// File: rtl/fll_tuner.sv
module fll_tuner #(
    parameter int CNT_W       = 16,
    parameter int TAP_W       = 8,
    parameter int RNG_W       = 3,
    parameter int MIN_TARGET  = 64,
    parameter int SYNC_STAGES = 2,
    parameter int TAP_INIT    = 128,
    parameter int RNG_INIT    = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             start,
    input  logic [CNT_W-1:0] target,
    output logic [TAP_W-1:0] fine_tap,
    output logic [RNG_W-1:0] coarse_sel,
    output logic             busy,
    output logic             locked,
    output logic             reject
);
    import fll_pkg::*;

    localparam logic [CNT_W-1:0] TGT_FLOOR = CNT_W'(MIN_TARGET);

    fll_state_e    state_q, state_d;
    logic          ref_rise;
    logic [CNT_W-1:0] meas;
    logic          tgt_ok, launch, refuse, sample, hit, step_up, step_dn;
    logic          reject_q;

    fll_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_async(ref_in),
        .rise     (ref_rise)
    );

    assign tgt_ok  = (target >= TGT_FLOOR);
    assign launch  = start &&  tgt_ok && (state_q != ST_TRACK);
    assign refuse  = start && !tgt_ok && (state_q != ST_TRACK);
    assign sample  = ref_rise && (state_q == ST_TRACK);
    assign hit     = sample && (meas == target);
    assign step_up = sample && (meas <  target);
    assign step_dn = sample && (meas >  target);

    fll_period_meter #(.CW(CNT_W)) u_meter (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (launch),
        .run  (state_q == ST_TRACK),
        .cap  (sample),
        .diff (meas)
    );

    fll_tap_stepper #(
        .TW(TAP_W), .RW(RNG_W), .TAP_INIT(TAP_INIT), .RNG_INIT(RNG_INIT)
    ) u_step (
        .clk  (clk),
        .rst_n(rst_n),
        .up   (step_up),
        .dn   (step_dn),
        .tap  (fine_tap),
        .rng  (coarse_sel)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_TRACK;
            ST_TRACK:  if (hit)    state_d = ST_LOCKED;
            ST_LOCKED: if (launch) state_d = ST_TRACK;
            default:               state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            reject_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            reject_q <= refuse;
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q == ST_TRACK);
        locked = (state_q == ST_LOCKED);
        reject = reject_q;
    end

    // R2: launch enters tracking with tap and range kept
    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && tgt_ok && !busy) |=>
            (busy && !locked && $stable(fine_tap) && $stable(coarse_sel)));
    // R3: refused start leaves the state alone
    assert_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !tgt_ok && !busy) |=> (!busy && reject && $stable(locked)));
    // R3: the refusal flag is a single-clock pulse
    assert_reject_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && !start) |=> !reject);
    // R9: exact match ends the run
    assert_match_locks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (locked && !busy));
    // R9: held outputs while locked
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !start) |=> ($stable(fine_tap) && $stable(coarse_sel) && locked));
endmodule

// File: tb/tb_fll_tuner.sv
module tb_fll_tuner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic        start = 1'b0;
    logic [15:0] target = 16'd100;
    logic [7:0]  fine_tap;
    logic [2:0]  coarse_sel;
    logic        busy, locked, reject;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fll_tuner dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .start(start), .target(target),
        .fine_tap(fine_tap), .coarse_sel(coarse_sel),
        .busy(busy), .locked(locked), .reject(reject)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; ref_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start(input int tgt);
        @(negedge clk);
        target = 16'(tgt);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    // first rise after 'first' negedges, later rises every 'per' negedges
    task automatic run_ref(input int first, input int per, input int count);
        ref_in = 1'b0;
        repeat (first) @(negedge clk);
        for (int i = 0; i < count; i++) begin
            ref_in = 1'b1;
            repeat (4) @(negedge clk);
            ref_in = 1'b0;
            repeat (per - 4) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 tap",    fine_tap, 8'h80);
        check("R1 range",  coarse_sel, 0);
        check("R1 busy",   busy, 0);
        check("R1 locked", locked, 0);
        check("R1 reject", reject, 0);
    endtask

    task automatic t_target_floor();
        do_reset();
        pulse_start(63);
        check("R3 busy after 63",   busy, 0);
        check("R3 reject pulse",    reject, 1);
        @(negedge clk);
        check("R3 reject one clock", reject, 0);
        pulse_start(64);
        check("R2 busy after 64",   busy, 1);
        check("R3 no reject at 64", reject, 0);
    endtask

    task automatic t_first_interval();
        do_reset();
        pulse_start(202);
        run_ref(200, 50, 1);
        check("R4 locked on first",  locked, 1);
        check("R4 tap unchanged",    fine_tap, 8'h80);
    endtask

    task automatic t_lock_and_restart();
        do_reset();
        pulse_start(100);
        run_ref(300, 100, 4);
        check("R9 locked",        locked, 1);
        check("R9 busy low",      busy, 0);
        check("R6 one step down", fine_tap, 8'h7F);
        check("R9 range held",    coarse_sel, 0);
        run_ref(30, 60, 3);
        check("R9 tap held",      fine_tap, 8'h7F);
        check("R9 still locked",  locked, 1);
        pulse_start(10);
        check("R3 locked kept",   locked, 1);
        check("R3 reject locked", reject, 1);
        pulse_start(120);
        check("R2 relaunch busy",   busy, 1);
        check("R2 relaunch unlock", locked, 0);
        check("R2 tap kept",        fine_tap, 8'h7F);
        run_ref(400, 120, 3);
        check("R9 relocked",        locked, 1);
        check("R6 second run step", fine_tap, 8'h7E);
    endtask

    task automatic t_climb();
        do_reset();
        pulse_start(1000);
        run_ref(50, 24, 5);
        check("R5 five steps",     fine_tap, 8'h85);
        check("R7 still tracking", busy, 1);
        run_ref(0, 24, 122);
        check("R7 before wrap tap",   fine_tap, 8'hFF);
        check("R7 before wrap range", coarse_sel, 0);
        run_ref(0, 24, 1);
        check("R7 wrap tap",   fine_tap, 8'h00);
        check("R7 wrap range", coarse_sel, 1);
        run_ref(0, 24, 1536);
        check("R7 range at top", coarse_sel, 7);
        check("R7 tap at top",   fine_tap, 8'h00);
        run_ref(0, 24, 256);
        check("R8 range ceiling", coarse_sel, 7);
        check("R8 tap wrapped",   fine_tap, 8'h00);
        target = 16'd64;
        run_ref(76, 24, 1);
        check("R10 new target tap", fine_tap, 8'hFF);
        check("R6 down carry",      coarse_sel, 6);
    endtask

    task automatic t_descent();
        do_reset();
        pulse_start(64);
        run_ref(100, 100, 128);
        check("R6 tap at zero",  fine_tap, 8'h00);
        check("R6 range zero",   coarse_sel, 0);
        run_ref(0, 100, 1);
        check("R8 tap wraps",    fine_tap, 8'hFF);
        check("R8 range floor",  coarse_sel, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_target_floor();
        t_first_interval();
        t_lock_and_restart();
        t_climb();
        t_descent();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule